// File: doc/BRIEF.md
# DMA Channel Control Register

This block is the control word of one DMA channel. Software reads and writes it over a simple single-cycle register port. It holds five things:

- the channel enable;
- a suspend request;
- seven interrupt enables;
- a link step mode bit;
- a two-bit priority.

The block also accepts a write-only reset command. Its outputs run to the channel's transfer engine: enable, suspend, mode and priority. It takes back the engine's status: idle, suspended, transfer error and transfer complete. It also takes seven interrupt event flags, which it gates with the enables.

Control of the enable is split between software and hardware. Only software can set it, and only hardware can clear it. A clear comes from an error, a completion or a reset command. A reset command acts only in a steady state. If it arrives at any other time it waits, and it takes effect in the first cycle the engine reaches a steady state. The mode and priority fields accept writes only while the channel is disabled.

Top module: `dma_chan_ctrl`

## Requirements
- R1: A write with bit 0 set, and bit 1 clear, enables the channel on the next clock. A write with bit 0 clear leaves the enable unchanged.
- R2: `engXferErr` or `engXferDone` clears the enable on the next clock. This clear wins over a software enable written in the same cycle.
- R3: A write with bit 1 set clears both the enable and the suspend bit, whatever bits 0 and 2 of the same word hold. Bit 1 always reads as 0, and writing 0 there changes nothing.
- R4: A reset command takes effect only when the channel is steady. Steady means the engine is idle and either the channel is disabled, or it is enabled and the engine reports suspended. A reset command written at any other time is held pending. It is applied on the first clock at which the steady condition holds.
- R5: Bit 2 is the suspend request. Writing 1 drives `chanSuspend` high, writing 0 drives it low, and the current value reads back in bit 2.
- R6: The link step bit (bit 16) and the priority field (bits 23:22) load only from writes made while the enable is 0. While the channel is enabled, writes leave both unchanged.
- R7: `chanPrio` carries one of four codes. In order of increasing precedence they are: 0 low priority with low weight, 1 low priority with mid weight, 2 low priority with high weight, 3 high priority. `linkStep` 1 selects a single pass over the current link entry, and 0 selects the whole list.
- R8: Bits 14:8 hold the interrupt enables. From bit 8 upward they cover: transfer complete, half transfer, data transfer error, link-update error, user setting error, suspension completed, trigger overrun. `engEvt[k]` carries the event of enable bit 8+k. `irqLines[k]` is `engEvt[k]` AND enable bit 8+k, and `chanIrq` is the OR of the seven lines.
- R9: After the system reset every held field and every output is 0, and the register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read value |
| engIdle | input | 1 | Engine reports idle |
| engSuspended | input | 1 | Engine reports suspension complete |
| engXferErr | input | 1 | Engine reports a bus or configuration error |
| engXferDone | input | 1 | Engine reports channel transfer complete |
| engEvt | input | 7 | Interrupt event flags |
| chanEnable | output | 1 | Channel enable to the engine |
| chanSuspend | output | 1 | Suspend request to the engine |
| linkStep | output | 1 | Link step mode to the engine |
| chanPrio | output | 2 | Priority code to the engine |
| irqLines | output | 7 | Per-event gated interrupts |
| chanIrq | output | 1 | Combined channel interrupt |

## Verification
Two functions can fall in the same cycle: a software write that sets the enable, and a hardware clear from an error or completion pulse. The bench drives both at one falling edge and expects the enable to read 0 after the next rising edge. The second overlap is a pending reset and the engine reaching a steady state. The bench holds a reset pending while the engine is busy, checks that the channel stays enabled, and then raises idle and suspended together. It expects enable and suspend both cleared one clock later.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  localparam int DATA_W   = 32;
  localparam int EN_BIT   = 0;
  localparam int RST_BIT  = 1;
  localparam int SUSP_BIT = 2;
  localparam int IE_LSB   = 8;
  localparam int IRQ_N    = 7;
  localparam int LSM_BIT  = 16;
  localparam int PRIO_LSB = 22;
  localparam int PRIO_W   = 2;
  localparam int IE_MSB   = IE_LSB + IRQ_N - 1;
  localparam int PRIO_MSB = PRIO_LSB + PRIO_W - 1;

  localparam logic [DATA_W-1:0] USED_MASK =
      (DATA_W'(1) << EN_BIT) | (DATA_W'(1) << RST_BIT) | (DATA_W'(1) << SUSP_BIT) |
      (DATA_W'((1 << IRQ_N) - 1) << IE_LSB) | (DATA_W'(1) << LSM_BIT) |
      (DATA_W'((1 << PRIO_W) - 1) << PRIO_LSB);

  typedef struct packed {
    logic setEn;
    logic clrEn;
    logic loadSusp;
    logic suspVal;
    logic loadIe;
    logic loadCfg;
  } ctrlStrobe_t;
endpackage

// File: rtl/dcc_ctrl.sv
module dcc_ctrl
  import dcc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        regWrEn,
  input  logic        wrEnBit,
  input  logic        wrRstBit,
  input  logic        wrSuspBit,
  input  logic        enState,
  input  logic        engIdle,
  input  logic        engSuspended,
  input  logic        engXferErr,
  input  logic        engXferDone,
  output ctrlStrobe_t strobe,
  output logic        resetPending
);
  logic rstReq;
  logic steady;
  logic applyRst;
  logic hwClr;
  logic pendReg;

  assign rstReq   = regWrEn & wrRstBit;
  // steady: idle and (disabled, or enabled and suspended)
  assign steady   = engIdle & (~enState | engSuspended);
  assign applyRst = (rstReq | pendReg) & steady;
  assign hwClr    = engXferErr | engXferDone;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pendReg <= 1'b0;
    else if (applyRst) pendReg <= 1'b0;
    else if (rstReq)   pendReg <= 1'b1;
  end

  always_comb begin
    strobe          = '0;
    strobe.clrEn    = hwClr | applyRst;
    strobe.setEn    = regWrEn & wrEnBit & ~rstReq;
    strobe.loadSusp = applyRst | (regWrEn & ~rstReq);
    strobe.suspVal  = applyRst ? 1'b0 : wrSuspBit;
    strobe.loadIe   = regWrEn;
    strobe.loadCfg  = regWrEn & ~enState;
  end

  assign resetPending = pendReg;
endmodule

// File: rtl/dcc_regs.sv
module dcc_regs
  import dcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strobe,
  input  logic [IRQ_N-1:0]  wrIe,
  input  logic              wrLsm,
  input  logic [PRIO_W-1:0] wrPrio,
  input  logic [IRQ_N-1:0]  engEvt,
  output logic              enState,
  output logic              suspState,
  output logic              lsmState,
  output logic [PRIO_W-1:0] prioState,
  output logic [DATA_W-1:0] rdWord,
  output logic [IRQ_N-1:0]  irqVec,
  output logic              irqAny
);
  logic [IRQ_N-1:0] ieState;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            enState <= 1'b0;
    else if (strobe.clrEn) enState <= 1'b0;
    else if (strobe.setEn) enState <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               suspState <= 1'b0;
    else if (strobe.loadSusp) suspState <= strobe.suspVal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             ieState <= '0;
    else if (strobe.loadIe) ieState <= wrIe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lsmState  <= 1'b0;
      prioState <= '0;
    end else if (strobe.loadCfg) begin
      lsmState  <= wrLsm;
      prioState <= wrPrio;
    end
  end

  always_comb begin
    rdWord                    = '0;
    rdWord[EN_BIT]            = enState;
    rdWord[SUSP_BIT]          = suspState;
    rdWord[IE_MSB:IE_LSB]     = ieState;
    rdWord[LSM_BIT]           = lsmState;
    rdWord[PRIO_MSB:PRIO_LSB] = prioState;
  end

  for (genvar k = 0; k < IRQ_N; k++) begin : g_irq
    assign irqVec[k] = engEvt[k] & ieState[k];
  end
  assign irqAny = |irqVec;
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              engIdle,
  input  logic              engSuspended,
  input  logic              engXferErr,
  input  logic              engXferDone,
  input  logic [IRQ_N-1:0]  engEvt,
  output logic              chanEnable,
  output logic              chanSuspend,
  output logic              linkStep,
  output logic [PRIO_W-1:0] chanPrio,
  output logic [IRQ_N-1:0]  irqLines,
  output logic              chanIrq
);
  ctrlStrobe_t strobe;
  logic        resetPending;
  logic        unusedWrBits;

  assign unusedWrBits = ^(regWrData & ~USED_MASK);

  dcc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn),
    .wrEnBit(regWrData[EN_BIT]), .wrRstBit(regWrData[RST_BIT]),
    .wrSuspBit(regWrData[SUSP_BIT]), .enState(chanEnable),
    .engIdle(engIdle), .engSuspended(engSuspended),
    .engXferErr(engXferErr), .engXferDone(engXferDone),
    .strobe(strobe), .resetPending(resetPending)
  );

  dcc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .wrIe(regWrData[IE_MSB:IE_LSB]), .wrLsm(regWrData[LSM_BIT]),
    .wrPrio(regWrData[PRIO_MSB:PRIO_LSB]), .engEvt(engEvt),
    .enState(chanEnable), .suspState(chanSuspend), .lsmState(linkStep),
    .prioState(chanPrio), .rdWord(regRdData), .irqVec(irqLines), .irqAny(chanIrq)
  );
endmodule

// File: rtl/dcc_chk.sv
module dcc_chk
  import dcc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              regWrEn,
  input logic [1:0]        wrCmd,
  input logic              rdRstBit,
  input logic              engIdle,
  input logic              engSuspended,
  input logic              engXferErr,
  input logic              engXferDone,
  input logic [IRQ_N-1:0]  engEvt,
  input logic              chanEnable,
  input logic              chanSuspend,
  input logic              linkStep,
  input logic [PRIO_W-1:0] chanPrio,
  input logic              chanIrq,
  input logic              resetPending
);
  // R2
  hw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (engXferErr || engXferDone) |=> !chanEnable);

  // R1
  sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && wrCmd == 2'b01 && !engXferErr && !engXferDone && !resetPending)
      |=> chanEnable);

  // R1
  no_self_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chanEnable && !regWrEn) |=> !chanEnable);

  // R3
  rst_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdRstBit);

  // R4
  steady_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((regWrEn && wrCmd[1] || resetPending) && engIdle && (!chanEnable || engSuspended))
      |=> (!chanEnable && !chanSuspend && !resetPending));

  // R6
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chanEnable |=> ($stable(chanPrio) && $stable(linkStep)));

  // R8
  irq_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chanIrq |-> (engEvt != '0));
endmodule

bind dma_chan_ctrl dcc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .wrCmd(regWrData[1:0]),
  .rdRstBit(regRdData[1]), .engIdle(engIdle), .engSuspended(engSuspended),
  .engXferErr(engXferErr), .engXferDone(engXferDone), .engEvt(engEvt),
  .chanEnable(chanEnable), .chanSuspend(chanSuspend), .linkStep(linkStep),
  .chanPrio(chanPrio), .chanIrq(chanIrq), .resetPending(resetPending)
);

// File: tb/sim_dma_chan_ctrl.sv
module sim_dma_chan_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        engIdle = 1'b1;
  logic        engSuspended = 1'b0;
  logic        engXferErr = 1'b0;
  logic        engXferDone = 1'b0;
  logic [6:0]  engEvt = '0;
  logic        chanEnable, chanSuspend, linkStep, chanIrq;
  logic [1:0]  chanPrio;
  logic [6:0]  irqLines;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_ctrl u0 (.*);

  function automatic logic [31:0] mk(bit en, bit rs, bit su, logic [6:0] ie, bit ls, logic [1:0] pr);
    logic [31:0] w = '0;
    w[0] = en; w[1] = rs; w[2] = su; w[14:8] = ie; w[16] = ls; w[23:22] = pr;
    return w;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic pulse(bit err, bit done);
    @(negedge clk);
    engXferErr = err; engXferDone = done;
    @(negedge clk);
    engXferErr = 1'b0; engXferDone = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 rd", regRdData, 32'h0);
    chk("R9 outs", {chanEnable, chanSuspend, linkStep, chanPrio, irqLines, chanIrq}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 / R7 sweep of mode and priority while disabled
    for (int p = 0; p < 4; p++)
      for (int l = 0; l < 2; l++) begin
        wr(mk(0, 0, 0, '0, l[0], p[1:0]));
        chk("R7 prio", {30'd0, chanPrio}, p);
        chk("R7 lsm", {31'd0, linkStep}, l);
        chk("R6 rd", regRdData, mk(0, 0, 0, '0, l[0], p[1:0]));
      end

    // R1 enable set; cfg loaded since enable was 0
    wr(mk(1, 0, 0, '0, 1, 2'd2));
    chk("R1 set", {31'd0, chanEnable}, 1);
    chk("R6 cfg at enable", {29'd0, linkStep, chanPrio}, 3'b110);
    // R6 lock
    wr(mk(1, 0, 0, '0, 0, 2'd1));
    chk("R6 locked", {29'd0, linkStep, chanPrio}, 3'b110);
    // R1 writing 0 ignored
    wr(mk(0, 0, 0, '0, 0, 2'd0));
    chk("R1 zero ignored", {31'd0, chanEnable}, 1);

    // R5 suspend / resume
    wr(mk(0, 0, 1, '0, 0, 0));
    chk("R5 susp", {30'd0, chanSuspend, regRdData[2]}, 2'b11);
    chk("R5 en kept", {31'd0, chanEnable}, 1);
    wr(mk(0, 0, 0, '0, 0, 0));
    chk("R5 resume", {30'd0, chanSuspend, regRdData[2]}, 2'b00);

    // R2 hardware clears
    pulse(0, 1);
    chk("R2 done clr", {31'd0, chanEnable}, 0);
    wr(mk(1, 0, 0, '0, 0, 0));
    pulse(1, 0);
    chk("R2 err clr", {31'd0, chanEnable}, 0);
    // R2 collision: set and clear in same cycle
    @(negedge clk);
    regWrEn = 1'b1; regWrData = mk(1, 0, 0, '0, 0, 0); engXferDone = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0; engXferDone = 1'b0;
    chk("R2 hw wins", {31'd0, chanEnable}, 0);

    // R3 reset when disabled: ignores en/susp of same word
    wr(mk(1, 1, 1, '0, 0, 0));
    chk("R3 rst word", {30'd0, chanEnable, chanSuspend}, 2'b00);
    chk("R3 rd bit1", {31'd0, regRdData[1]}, 0);

    // R4 reset when enabled, suspended and idle
    wr(mk(1, 0, 1, '0, 0, 0));
    engSuspended = 1'b1;
    wr(mk(0, 1, 1, '0, 0, 0));
    chk("R4 steady susp", {30'd0, chanEnable, chanSuspend}, 2'b00);
    engSuspended = 1'b0;

    // R4 pending reset while busy
    wr(mk(1, 0, 0, '0, 0, 0));
    engIdle = 1'b0;
    wr(mk(1, 1, 0, '0, 0, 0));
    chk("R4 held", {31'd0, chanEnable}, 1);
    @(negedge clk);
    chk("R4 still held", {31'd0, chanEnable}, 1);
    wr(mk(0, 0, 1, '0, 0, 0));
    chk("R4 susp while pending", {30'd0, chanEnable, chanSuspend}, 2'b11);
    engIdle = 1'b1; engSuspended = 1'b1;
    @(negedge clk);
    chk("R4 applied", {30'd0, chanEnable, chanSuspend}, 2'b00);
    engSuspended = 1'b0;

    // R8 exhaustive mask x event sweep
    for (int m = 0; m < 128; m++) begin
      wr(mk(0, 0, 0, m[6:0], 0, 0));
      chk("R8 ie rd", {25'd0, regRdData[14:8]}, m);
      for (int e = 0; e < 128; e++) begin
        engEvt = e[6:0];
        #1;
        chk("R8 lines", {25'd0, irqLines}, e & m);
        chk("R8 any", {31'd0, chanIrq}, ((e & m) != 0) ? 1 : 0);
      end
      engEvt = '0;
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule